// File: doc/BRIEF.md
# Multi-Group Conversion Trigger Controller

This block is the digital sequencing logic for a successive-approximation converter. It holds a small bank of channel-group control registers. Each register selects an input channel and enables an interrupt on completion. At most one group owns the converter at any moment. Software reaches the block through a simple single-cycle register bus. Conversions start in one of two ways. In software mode, a write to group 0 starts a conversion. In hardware mode, each group has its own trigger input.

The block drives an abstract converter through a start pulse and an abort pulse, together with a channel number. It watches the converter's busy, done and result signals. When a conversion finishes, the result is stored in the owning group's result register and that group's completion flag is set. Reading the result register clears the flag. An optional continuous mode restarts the same group after each completion. An optional overwrite mode decides whether a fresh result may replace one that has not yet been read.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset the converter is idle and every completion flag is clear. This means `conv_start`, `conv_abort` and `irq` are low, and the status register and every result register read as zero.
- R2: In software mode, a write to group 0 makes `conv_start` pulse for one cycle, two clock edges after the write edge. `conv_chan` carries the written channel. Status bit 0 (active) is high from the start pulse until the edge on which `conv_done` is taken.
- R3: In software mode, writes to groups 1 and above never start a conversion, and the hardware trigger inputs have no effect.
- R4: Writing the control register of the group that owns the running conversion makes `conv_abort` pulse one edge later and clears the active bit. In software mode, group 0 then restarts with the newly written channel. In hardware mode, the group waits for its next trigger.
- R5: Writing the control register of a group that is not active leaves the running conversion undisturbed.
- R6: In hardware mode, a one-cycle pulse on `hw_trig[n]` starts group n when the converter is idle. A pulse that arrives while a conversion is running is held pending. Held groups are started one at a time, lowest index first.
- R7: On a completion, `conv_result` is stored in the owning group's result register. That group's flag (status bit 8+n) is set on the same edge.
- R8: Reading a group's result register clears that group's completion flag.
- R9: `irq` is high exactly when some group has its flag set and its interrupt enable set.
- R10: With overwrite off, a result for a group whose flag is still set is discarded. With overwrite on, the new result replaces the old one.
- R11: With continuous mode on, the group that just completed is started again without any further write or trigger.
- R12: Register map (word addresses, G groups):
  - Addresses 0..G-1 are the group control registers. Bits 4:0 hold the channel and bit 7 holds the interrupt enable.
  - Addresses G..2G-1 are the result registers.
  - Address 2G is the configuration register. Bit 0 selects hardware mode, bit 1 enables continuous mode and bit 2 enables overwrite. It reads back as written.
  - Address 2G+1 is the status register. Bit 0 is active and bits 8+n are the completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of a result register clears its flag) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| hw_trig | input | NUM_GROUPS | Per-group hardware trigger pulses |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_abort | output | 1 | One-cycle abort pulse to the converter |
| conv_chan | output | CH_W | Channel for the conversion being started |
| conv_busy | input | 1 | Converter is running |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | RES_W | Converter result, valid with `conv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
Each result has a fixed latency from its stimulus. The start pulse comes two edges after the triggering write or trigger edge. The abort pulse comes one edge after the write that hits the active group. A flag rises on the edge that takes `conv_done`, and falls on the edge that ends a result read. The bench drives every input at the falling edge and samples at the following falling edges. It counts exactly those edges before checking, and it waits on port activity only for the converter-model latency. A swept channel pass in software mode is followed by directed hardware-mode sequences that cover pending order, aborts, discard versus overwrite, and continuous restart.

// File: rtl/adc_trig_pkg.sv
// Shared field positions and configuration type for the conversion trigger controller.
package adc_trig_pkg;
    localparam int IE_BIT        = 7;
    localparam int CFG_HW_BIT    = 0;
    localparam int CFG_CONT_BIT  = 1;
    localparam int CFG_OVWR_BIT  = 2;
    localparam int STAT_FLAG_LSB = 8;

    typedef struct packed {
        logic ovwr;
        logic cont;
        logic hw_mode;
    } glob_cfg_t;
endpackage

// File: rtl/adc_grp_cfg.sv
// Channel-group control registers: one channel field and one interrupt
// enable per group, written from the register bus.
// Assumes CH_W <= IE_BIT so the fields do not overlap.
module adc_grp_cfg #(
    parameter int G    = 4,
    parameter int CH_W = 5,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [G-1:0][CH_W-1:0]   grp_chan,
    output logic [G-1:0]             grp_ie,
    output logic [G-1:0]             grp_wr_hit
);
    import adc_trig_pkg::*;

    for (genvar g = 0; g < G; g++) begin : g_grp
        assign grp_wr_hit[g] = bus_wr && (bus_addr == AW'(g));

        // Capture the channel and enable on a write to this group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_chan[g] <= '0;
                grp_ie[g]   <= 1'b0;
            end else if (grp_wr_hit[g]) begin
                grp_chan[g] <= bus_wdata[CH_W-1:0];
                grp_ie[g]   <= bus_wdata[IE_BIT];
            end
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: tracks the one active group, holds pending start
// requests, issues start/abort pulses and reports completions.
// Assumes conv_done is a one-cycle pulse with conv_result valid alongside,
// and that conv_busy falls no later than the edge after an abort.
module adc_conv_seq #(
    parameter int G    = 4,
    parameter int CH_W = 5,
    parameter int GW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hw_mode,
    input  logic                     cont_en,
    input  logic [G-1:0]             grp_wr_hit,
    input  logic [G-1:0][CH_W-1:0]   grp_chan,
    input  logic [G-1:0]             hw_trig,
    input  logic                     conv_busy,
    input  logic                     conv_done,
    output logic                     conv_start,
    output logic                     conv_abort,
    output logic [CH_W-1:0]          conv_chan,
    output logic                     act_valid,
    output logic [GW-1:0]            act_grp,
    output logic                     deliver,
    output logic [GW-1:0]            deliver_grp
);
    logic [G-1:0]  pend;
    logic [G-1:0]  eligible;
    logic [G-1:0]  pend_set;
    logic [G-1:0]  act_oh;
    logic [G-1:0]  sel_oh;
    logic [GW-1:0] sel;
    logic          found;
    logic          wr_active;
    logic          done_ok;
    logic          can_start;

    assign act_oh    = G'(1) << act_grp;
    assign wr_active = act_valid && |(grp_wr_hit & act_oh);
    assign done_ok   = act_valid && conv_done && !wr_active;
    assign eligible  = hw_mode ? pend : (pend & G'(1));
    assign can_start = !act_valid && !conv_busy && |eligible;
    assign sel_oh    = G'(1) << sel;

    assign deliver     = done_ok;
    assign deliver_grp = act_grp;

    // Pick the lowest-index eligible group.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < G; i++) begin
            if (eligible[i] && !found) begin
                sel   = GW'(i);
                found = 1'b1;
            end
        end
    end

    // Gather new start requests from software writes, triggers and restarts.
    always_comb begin
        pend_set = hw_mode ? hw_trig : '0;
        if (!hw_mode && grp_wr_hit[0]) pend_set[0] = 1'b1;
        if (done_ok && cont_en)        pend_set    = pend_set | act_oh;
    end

    // Pending requests: a granted one clears, a new one wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~(can_start ? sel_oh : '0)) | pend_set;
    end

    // Ownership of the converter and the pulses that go with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid  <= 1'b0;
            act_grp    <= '0;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= can_start;
            conv_abort <= wr_active;
            if (wr_active || done_ok) begin
                act_valid <= 1'b0;
            end else if (can_start) begin
                act_valid <= 1'b1;
                act_grp   <= sel;
                conv_chan <= grp_chan[sel];
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Per-group result registers and completion flags with read-to-clear,
// optional overwrite protection, and the combined interrupt.
// Assumes deliver is a one-cycle pulse qualified by the sequencer.
module adc_result_bank #(
    parameter int G     = 4,
    parameter int RES_W = 12,
    parameter int GW    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     deliver,
    input  logic [GW-1:0]            deliver_grp,
    input  logic [RES_W-1:0]         conv_result,
    input  logic                     ovwr,
    input  logic [G-1:0]             rd_hit,
    input  logic [G-1:0]             grp_ie,
    output logic [G-1:0][RES_W-1:0]  res_val,
    output logic [G-1:0]             res_flag,
    output logic                     irq
);
    for (genvar g = 0; g < G; g++) begin : g_res
        logic cap;
        assign cap = deliver && (deliver_grp == GW'(g)) && (!res_flag[g] || ovwr);

        // Store a permitted result; a read clears the flag unless a store coincides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_val[g]  <= '0;
                res_flag[g] <= 1'b0;
            end else if (cap) begin
                res_val[g]  <= conv_result;
                res_flag[g] <= 1'b1;
            end else if (rd_hit[g]) begin
                res_flag[g] <= 1'b0;
            end
        end
    end

    assign irq = |(res_flag & grp_ie);
endmodule

// File: rtl/adc_trig_ctrl.sv
// Top of the conversion trigger controller: address decode, global
// configuration register, read multiplexer and the three sub-blocks.
// Assumes DW >= STAT_FLAG_LSB + NUM_GROUPS and CH_W <= 7.
module adc_trig_ctrl #(
    parameter int NUM_GROUPS = 4,
    parameter int CH_W       = 5,
    parameter int RES_W      = 12,
    parameter int DW         = 32,
    localparam int AW        = $clog2(2 * NUM_GROUPS + 2),
    localparam int GW        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NUM_GROUPS-1:0]  hw_trig,
    output logic                   conv_start,
    output logic                   conv_abort,
    output logic [CH_W-1:0]        conv_chan,
    input  logic                   conv_busy,
    input  logic                   conv_done,
    input  logic [RES_W-1:0]       conv_result,
    output logic                   irq
);
    import adc_trig_pkg::*;

    localparam int G         = NUM_GROUPS;
    localparam int CFG_ADDR  = 2 * G;
    localparam int STAT_ADDR = 2 * G + 1;

    glob_cfg_t                 cfg;
    logic                      hw_mode;
    logic [G-1:0][CH_W-1:0]    grp_chan;
    logic [G-1:0]              grp_ie;
    logic [G-1:0]              grp_wr_hit;
    logic [G-1:0]              rd_hit;
    logic [G-1:0][RES_W-1:0]   res_val;
    logic [G-1:0]              res_flag;
    logic                      act_valid;
    logic [GW-1:0]             act_grp;
    logic                      deliver;
    logic [GW-1:0]             deliver_grp;

    assign hw_mode = cfg.hw_mode;

    for (genvar g = 0; g < G; g++) begin : g_rd
        assign rd_hit[g] = bus_rd && (bus_addr == AW'(G + g));
    end

    // Global configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (bus_wr && bus_addr == AW'(CFG_ADDR)) begin
            cfg.hw_mode <= bus_wdata[CFG_HW_BIT];
            cfg.cont    <= bus_wdata[CFG_CONT_BIT];
            cfg.ovwr    <= bus_wdata[CFG_OVWR_BIT];
        end
    end

    // Read multiplexer over all register classes.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < G; i++) begin
            if (bus_addr == AW'(i)) begin
                bus_rdata[CH_W-1:0] = grp_chan[i];
                bus_rdata[IE_BIT]   = grp_ie[i];
            end
            if (bus_addr == AW'(G + i)) bus_rdata[RES_W-1:0] = res_val[i];
        end
        if (bus_addr == AW'(CFG_ADDR)) begin
            bus_rdata[CFG_HW_BIT]   = cfg.hw_mode;
            bus_rdata[CFG_CONT_BIT] = cfg.cont;
            bus_rdata[CFG_OVWR_BIT] = cfg.ovwr;
        end
        if (bus_addr == AW'(STAT_ADDR)) begin
            bus_rdata[0]                          = act_valid;
            bus_rdata[STAT_FLAG_LSB +: G]         = res_flag;
        end
    end

    adc_grp_cfg #(.G(G), .CH_W(CH_W), .AW(AW), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .grp_chan   (grp_chan),
        .grp_ie     (grp_ie),
        .grp_wr_hit (grp_wr_hit)
    );

    adc_conv_seq #(.G(G), .CH_W(CH_W), .GW(GW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_mode     (cfg.hw_mode),
        .cont_en     (cfg.cont),
        .grp_wr_hit  (grp_wr_hit),
        .grp_chan    (grp_chan),
        .hw_trig     (hw_trig),
        .conv_busy   (conv_busy),
        .conv_done   (conv_done),
        .conv_start  (conv_start),
        .conv_abort  (conv_abort),
        .conv_chan   (conv_chan),
        .act_valid   (act_valid),
        .act_grp     (act_grp),
        .deliver     (deliver),
        .deliver_grp (deliver_grp)
    );

    adc_result_bank #(.G(G), .RES_W(RES_W), .GW(GW)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .deliver     (deliver),
        .deliver_grp (deliver_grp),
        .conv_result (conv_result),
        .ovwr        (cfg.ovwr),
        .rd_hit      (rd_hit),
        .grp_ie      (grp_ie),
        .res_val     (res_val),
        .res_flag    (res_flag),
        .irq         (irq)
    );
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
// Protocol checker for the conversion trigger controller, bound to the top.
// Observes bus strobes, converter pulses and the sequencer's ownership state.
module adc_trig_ctrl_chk #(
    parameter int NUM_GROUPS = 4,
    parameter int AW         = 4,
    parameter int GW         = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [AW-1:0]         bus_addr,
    input logic                  conv_start,
    input logic                  conv_abort,
    input logic                  irq,
    input logic                  act_valid,
    input logic [GW-1:0]         act_grp,
    input logic                  deliver,
    input logic [GW-1:0]         deliver_grp,
    input logic                  hw_mode,
    input logic [NUM_GROUPS-1:0] grp_ie,
    input logic [NUM_GROUPS-1:0] res_flag
);
    // R2: a start only claims an idle converter
    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (act_valid && !$past(act_valid)));

    // R2: the start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3: software mode only ever runs group 0
    p_sw_group0_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !$past(hw_mode)) |-> (act_grp == '0));

    // R4: a write to the owning group aborts it on the next edge
    p_abort_on_active_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && bus_wr && bus_addr == AW'(act_grp)) |=> (conv_abort && !act_valid));

    // R4: start and abort never coincide
    p_no_start_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && conv_abort));

    // R9: a completion on an enabled group raises the interrupt
    p_irq_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && grp_ie[deliver_grp] && !bus_wr && !bus_rd) |=> irq);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rd_chk
        // R8: a result read clears the flag unless a store coincides
        p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == AW'(NUM_GROUPS + g) && !(deliver && deliver_grp == GW'(g)))
            |=> !res_flag[g]);
    end
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS), .AW(AW), .GW(GW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .conv_start  (conv_start),
    .conv_abort  (conv_abort),
    .irq         (irq),
    .act_valid   (act_valid),
    .act_grp     (act_grp),
    .deliver     (deliver),
    .deliver_grp (deliver_grp),
    .hw_mode     (hw_mode),
    .grp_ie      (grp_ie),
    .res_flag    (res_flag)
);

// File: tb/tb_adc_trig_ctrl.sv
// Self-checking bench with a fixed-latency converter model.
module tb_adc_trig_ctrl;
    localparam int G     = 4;
    localparam int CH_W  = 5;
    localparam int RES_W = 12;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int LAT   = 6;
    localparam int CFG   = 8;
    localparam int STAT  = 9;
    localparam logic [DW-1:0] IE = 32'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [G-1:0] hw_trig = '0;
    logic conv_start, conv_abort, irq;
    logic [CH_W-1:0] conv_chan;
    logic conv_busy, conv_done;
    logic [RES_W-1:0] conv_result;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_trig(hw_trig), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_chan(conv_chan), .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq)
    );

    // Converter model: fixed latency, result derived from the channel.
    logic [CH_W-1:0] m_ch;
    int m_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_busy <= 1'b0; conv_done <= 1'b0; conv_result <= '0; m_cnt <= 0; m_ch <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_abort) begin
                conv_busy <= 1'b0; m_cnt <= 0;
            end else if (conv_start) begin
                conv_busy <= 1'b1; m_cnt <= LAT; m_ch <= conv_chan;
            end else if (conv_busy) begin
                if (m_cnt == 1) begin
                    conv_done   <= 1'b1;
                    conv_busy   <= 1'b0;
                    conv_result <= RES_W'(int'(m_ch) * 37 + 11);
                end
                m_cnt <= m_cnt - 1;
            end
        end
    end

    function automatic logic [DW-1:0] exp_res(input int ch);
        return DW'((ch * 37 + 11) & 12'hfff);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic trig(input logic [G-1:0] t);
        hw_trig = t;
        @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic wait_done(input string req);
        int k;
        for (k = 0; k < 100 && !conv_done; k++) @(negedge clk);
        if (!conv_done) check(req, 32'h0, 32'h1);
    endtask

    task automatic wait_start(input string req);
        int k;
        for (k = 0; k < 100 && !conv_start; k++) @(negedge clk);
        if (!conv_start) check(req, 32'h0, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 start", 32'(conv_start), 0);
        check("R1 abort", 32'(conv_abort), 0);
        check("R1 irq", 32'(irq), 0);
        rd(STAT, d); check("R1 status", d, 0);
        for (int g = 0; g < G; g++) begin
            rd(G + g, d); check("R1 result", d, 0);
        end

        // R2 R7 R8 R9: software sweep over every channel
        for (int ch = 0; ch < 32; ch++) begin
            wr(0, IE | DW'(ch));
            check("R2 no early start", 32'(conv_start), 0);
            tick();
            check("R2 start pulse", 32'(conv_start), 1);
            check("R2 channel", 32'(conv_chan), DW'(ch));
            rd(STAT, d); check("R2 active", d & 1, 1);
            wait_done("R2 done timeout");
            rd(STAT, d); check("R2 active at done", d & 1, 1);
            rd(STAT, d); check("R7 flag set", d, 32'h100);
            check("R9 irq high", 32'(irq), 1);
            rd(G, d); check("R7 result", d, exp_res(ch));
            check("R8 irq after read", 32'(irq), 0);
        end
        rd(STAT, d); check("R8 flags clear", d, 0);

        // R3: upper groups and triggers ignored in software mode
        wr(1, 32'd1); wr(2, 32'd2); wr(3, 32'd3);
        trig('1);
        for (int k = 0; k < 10; k++) begin
            check("R3 no start", 32'(conv_start), 0);
            tick();
        end
        rd(STAT, d); check("R3 idle", d, 0);

        // R4: software abort and restart with new channel
        wr(0, IE | 32'd3);
        tick(); check("R4 first start", 32'(conv_start), 1);
        tick(); tick();
        wr(0, IE | 32'd9);
        check("R4 abort pulse", 32'(conv_abort), 1);
        rd(STAT, d); check("R4 inactive", d & 1, 0);
        check("R4 no start yet", 32'(conv_start), 0);
        tick();
        check("R4 restart", 32'(conv_start), 1);
        check("R4 new channel", 32'(conv_chan), 9);
        wait_done("R4 done timeout");
        tick();
        rd(G, d); check("R4 result", d, exp_res(9));

        // R12: configuration readback; R5 R6: hardware mode ordering
        wr(CFG, 32'd1);
        rd(CFG, d); check("R12 cfg readback", d, 1);
        wr(1, IE | 32'd11); wr(2, IE | 32'd12); wr(3, IE | 32'd13); wr(0, IE | 32'd4);
        tick();
        check("R3 hw writes no start", 32'(conv_start), 0);
        rd(0, d); check("R12 ctrl readback", d, IE | 32'd4);
        trig(4'b0100);
        tick();
        check("R6 start grp2", 32'(conv_start), 1);
        check("R6 chan grp2", 32'(conv_chan), 12);
        trig(4'b1010);
        wr(0, IE | 32'd6);
        check("R5 no abort", 32'(conv_abort), 0);
        rd(STAT, d); check("R5 still active", d & 1, 1);
        wait_done("R6 done2");
        tick();
        wait_start("R6 start1");
        check("R6 lowest first", 32'(conv_chan), 11);
        tick();
        wait_done("R6 done1");
        tick();
        wait_start("R6 start3");
        check("R6 then grp3", 32'(conv_chan), 13);
        tick();
        wait_done("R6 done3");
        tick(); tick();
        rd(STAT, d); check("R6 flags", d, 32'hE00);
        rd(5, d); check("R7 res grp1", d, exp_res(11));
        rd(6, d); check("R7 res grp2", d, exp_res(12));
        rd(7, d); check("R7 res grp3", d, exp_res(13));
        for (int k = 0; k < 8; k++) begin
            check("R3 grp0 hw write no start", 32'(conv_start), 0);
            tick();
        end

        // R4: hardware abort, no restart
        trig(4'b0010);
        tick();
        check("R4 hw start", 32'(conv_chan), 11);
        tick();
        wr(1, IE | 32'd11);
        check("R4 hw abort", 32'(conv_abort), 1);
        for (int k = 0; k < 12; k++) begin
            check("R4 hw no restart", 32'(conv_start), 0);
            tick();
        end
        rd(STAT, d); check("R4 no flag", d, 0);

        // R10: discard versus overwrite
        trig(4'b1000); wait_done("R10 d1"); tick();
        wr(3, IE | 32'd20);
        trig(4'b1000); wait_done("R10 d2"); tick();
        rd(7, d); check("R10 discard keeps old", d, exp_res(13));
        wr(CFG, 32'd5);
        trig(4'b1000); wait_done("R10 d3"); tick();
        wr(3, IE | 32'd21);
        trig(4'b1000); wait_done("R10 d4"); tick();
        rd(7, d); check("R10 overwrite replaces", d, exp_res(21));

        // R9: flag without enable leaves irq low
        wr(CFG, 32'd1);
        wr(2, 32'd12);
        trig(4'b0100); wait_done("R9 done"); tick();
        rd(STAT, d); check("R9 flag set", d, 32'h400);
        check("R9 irq masked", 32'(irq), 0);
        wr(2, IE | 32'd12);
        check("R9 irq on enable", 32'(irq), 1);
        rd(6, d);
        check("R9 irq after read", 32'(irq), 0);

        // R11: continuous restart in software mode
        wr(CFG, 32'd2);
        wr(0, 32'd5);
        wait_start("R11 start a");
        check("R11 chan a", 32'(conv_chan), 5);
        tick();
        wait_done("R11 done a");
        tick();
        wait_start("R11 restart");
        check("R11 chan b", 32'(conv_chan), 5);
        wr(CFG, 32'd0);
        wait_done("R11 done b");
        tick();
        for (int k = 0; k < 12; k++) begin
            check("R11 stops", 32'(conv_start), 0);
            tick();
        end
        rd(G, d); check("R11 result", d, exp_res(5));
        rd(STAT, d); check("R11 settled", d, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule